// File: doc/BRIEF.md
# Power-Up Reset Timeout Sequencer

This block produces the internal reset of a small microcontroller core. After a power-on pulse it runs two delays, one after the other. The first is a power-up delay, timed on a slow internal RC tick. The second is an oscillator start-up delay, timed on the main oscillator clock. The core stays in reset until every delay that applies has finished and the external reset pin has been released. The oscillator mode and an active-low configuration enable decide which delays apply. With an RC oscillator and the power-up delay disabled, there is no delay at all.

Both delays are measured from the power-on event and not from the external pin. A board that holds the pin low past the end of the delays therefore starts the core within a couple of oscillator cycles of releasing the pin. This lets several parts start in lockstep.

A wake from sleep in a crystal-type mode runs only the oscillator start-up delay. In an RC mode, a wake has no effect on the reset.

Top module: `pwrup_rst_seq`

## Requirements
- R1: `core_rst` is 1 whenever `por` is 1.
- R2: When `pwrt_en_n` is 0, the power-up delay lasts `PWRT_TICKS` rising edges of `clk_rc`, counted from the fall of `por`. Reset is not released before this delay ends.
- R3: When `pwrt_en_n` is 1, the power-up delay is skipped. In a crystal-type mode reset falls after 66 to 68 oscillator cycles when `OST_CYCLES` is 64, with no RC ticks involved.
- R4: When `osc_xtal` is 1 (crystal-type mode), the start-up delay of `OST_CYCLES` rising edges of `clk_osc` begins only after the power-up delay has been seen done.
- R5: When `osc_xtal` is 0 (RC mode), the start-up delay is never run. With the power-up delay enabled, reset falls within 3 to 5 oscillator cycles after that delay ends.
- R6: With `osc_xtal` 0 and `pwrt_en_n` 1, reset falls within 4 `clk_osc` edges after `por` falls, provided `ext_rst_n` is 1.
- R7: A `wake` pulse sampled in crystal-type mode, while no delay is running, raises `core_rst` at that edge. `core_rst` stays high for exactly `OST_CYCLES` edges and does not rerun the power-up delay.
- R8: A `wake` pulse in RC mode has no effect: `core_rst` stays 0.
- R9: `core_rst` is 1 while the two-flop-synchronised `ext_rst_n` is 0. If the delays have expired while the pin was low, reset falls exactly 2 `clk_osc` edges after the pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Slow internal RC tick that times the power-up delay |
| clk_osc | input | 1 | Main oscillator clock; times the start-up delay and drives the output |
| por | input | 1 | Power-on pulse, active high, asynchronous restart of all state |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wake | input | 1 | Wake-from-sleep event, synchronous to `clk_osc` |
| pwrt_en_n | input | 1 | Power-up delay enable, 0 = run the delay (static configuration) |
| osc_xtal | input | 1 | 1 = crystal-type oscillator mode, 0 = RC mode (static configuration) |
| core_rst | output | 1 | Internal reset to the core, active high |

## Verification
On every oscillator cycle, the assertions check the following:
- the power-on pulse and a low synchronised pin force reset;
- the start-up delay never runs before the power-up delay is seen done, and never runs in RC mode;
- a wake in crystal mode starts the start-up delay, and a wake in RC mode leaves the sequencer idle;
- the start-up counter stays in range.

Only the bench scenarios can show the end-to-end lengths: the total power-up timeout in each of the four configurations, the exact wake hold time, and the two-edge release after a pin held past expiry. These lengths cross the clock domains and span hundreds of cycles.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    OST_WAIT = 2'd0,
    OST_RUN  = 2'd1,
    OST_DONE = 2'd2
  } ost_state_e;

  // Width of a counter that must hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // Total reset time in oscillator cycles for a given configuration,
  // ignoring clock-crossing jitter (used only as documentation aid)
  function automatic int nominal_osc_cycles(input int rc_ticks, input int rc_ratio,
                                            input int ost_cycles, input bit pwrt_on,
                                            input bit xtal);
    return (pwrt_on ? rc_ticks * rc_ratio : 0) + (xtal ? ost_cycles : 0);
  endfunction

endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/rst_pwrt_timer.sv
module rst_pwrt_timer
  import rst_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 18432
) (
  input  logic clk_rc,
  input  logic por,
  input  logic en_n,
  output logic done_o
);
  localparam int PW = cnt_width(PWRT_TICKS);
  localparam logic [PW-1:0] P_LAST = PW'(PWRT_TICKS - 1);

  logic [PW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_rc or posedge por) begin
    if (por) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!en_n && !done_q) begin
      if (cnt_q == P_LAST) done_q <= 1'b1;
      else                 cnt_q  <= cnt_q + 1'b1;
    end
  end

  // A disabled timer reports done at once so its phase is skipped
  assign done_o = en_n | done_q;
endmodule

// File: rtl/rst_ost_timer.sv
module rst_ost_timer
  import rst_seq_pkg::*;
#(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk_osc,
  input  logic por,
  input  logic pwrt_done_s,
  input  logic osc_xtal,
  input  logic wake,
  output logic run_o,
  output logic done_o,
  output logic [cnt_width(OST_CYCLES)-1:0] cnt_o
);
  localparam int OW = cnt_width(OST_CYCLES);
  localparam logic [OW-1:0] O_LAST = OW'(OST_CYCLES - 1);

  ost_state_e    st_q;
  logic [OW-1:0] cnt_q;

  always_ff @(posedge clk_osc or posedge por) begin
    if (por) begin
      st_q  <= OST_WAIT;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        OST_WAIT: if (pwrt_done_s) begin
          st_q  <= osc_xtal ? OST_RUN : OST_DONE;
          cnt_q <= '0;
        end
        OST_RUN: begin
          if (cnt_q == O_LAST) st_q  <= OST_DONE;
          else                 cnt_q <= cnt_q + 1'b1;
        end
        OST_DONE: if (wake && osc_xtal) begin
          st_q  <= OST_RUN;
          cnt_q <= '0;
        end
        default: st_q <= OST_WAIT;
      endcase
    end
  end

  assign run_o  = (st_q == OST_RUN);
  assign done_o = (st_q == OST_DONE);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import rst_seq_pkg::*;
#(
  parameter int PWRT_TICKS = 18432,
  parameter int OST_CYCLES = 1024
) (
  input  logic clk_rc,
  input  logic clk_osc,
  input  logic por,
  input  logic ext_rst_n,
  input  logic wake,
  input  logic pwrt_en_n,
  input  logic osc_xtal,
  output logic core_rst
);
  localparam int OW = cnt_width(OST_CYCLES);

  logic          pwrt_done;
  logic          pwrt_done_s;
  logic          pin_s;
  logic          ost_run;
  logic          ost_done;
  logic          ost_busy;
  logic [OW-1:0] ost_cnt;

  rst_pwrt_timer #(.PWRT_TICKS(PWRT_TICKS)) u_pwrt (
    .clk_rc (clk_rc),
    .por    (por),
    .en_n   (pwrt_en_n),
    .done_o (pwrt_done)
  );

  rst_sync2 #(.RST_VAL(1'b0)) u_sync_pwrt (
    .clk  (clk_osc),
    .arst (por),
    .d    (pwrt_done),
    .q    (pwrt_done_s)
  );

  rst_sync2 #(.RST_VAL(1'b0)) u_sync_pin (
    .clk  (clk_osc),
    .arst (por),
    .d    (ext_rst_n),
    .q    (pin_s)
  );

  rst_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk_osc     (clk_osc),
    .por         (por),
    .pwrt_done_s (pwrt_done_s),
    .osc_xtal    (osc_xtal),
    .wake        (wake),
    .run_o       (ost_run),
    .done_o      (ost_done),
    .cnt_o       (ost_cnt)
  );

  assign ost_busy = ~ost_done;
  assign core_rst = por | ~pwrt_done_s | ost_busy | ~pin_s;
endmodule

// File: rtl/pwrup_rst_seq_chk.sv
module pwrup_rst_seq_chk #(
  parameter int OST_CYCLES = 1024,
  parameter int OW = 11
) (
  input logic          clk_osc,
  input logic          por,
  input logic          pin_s,
  input logic          pwrt_done_s,
  input logic          ost_run,
  input logic          ost_done,
  input logic [OW-1:0] ost_cnt,
  input logic          wake,
  input logic          osc_xtal,
  input logic          core_rst
);
  AST_POR_HOLDS: assert property (@(posedge clk_osc) por |-> core_rst); // R1

  AST_PIN_HOLDS: assert property (@(posedge clk_osc) disable iff (por)
    !pin_s |-> core_rst); // R9

  AST_OST_AFTER_PWRT: assert property (@(posedge clk_osc) disable iff (por)
    ost_run |-> pwrt_done_s); // R4

  AST_RC_NO_OST: assert property (@(posedge clk_osc) disable iff (por)
    ost_run |-> osc_xtal); // R5

  AST_WAKE_STARTS_OST: assert property (@(posedge clk_osc) disable iff (por)
    (ost_done && wake && osc_xtal) |=> ost_run); // R7

  AST_RC_WAKE_IDLE: assert property (@(posedge clk_osc) disable iff (por)
    (ost_done && wake && !osc_xtal) |=> ost_done); // R8

  AST_OST_CNT_RANGE: assert property (@(posedge clk_osc) disable iff (por)
    ost_run |-> (32'(ost_cnt) < OST_CYCLES)); // R4

  AST_RELEASE_NEEDS_ALL: assert property (@(posedge clk_osc) disable iff (por)
    !core_rst |-> (ost_done && pin_s && pwrt_done_s)); // R2
endmodule

bind pwrup_rst_seq pwrup_rst_seq_chk #(.OST_CYCLES(OST_CYCLES), .OW(OW)) u_chk (
  .clk_osc     (clk_osc),
  .por         (por),
  .pin_s       (pin_s),
  .pwrt_done_s (pwrt_done_s),
  .ost_run     (ost_run),
  .ost_done    (ost_done),
  .ost_cnt     (ost_cnt),
  .wake        (wake),
  .osc_xtal    (osc_xtal),
  .core_rst    (core_rst)
);

// File: tb/pwrup_rst_seq_tb.sv
`timescale 1ns/1ps
module pwrup_rst_seq_tb;
  localparam int P   = 40;  // RC ticks of power-up delay
  localparam int OST = 64;  // oscillator cycles of start-up delay
  localparam int RAT = 4;   // clk_rc period / clk_osc period

  logic clk_rc = 1'b0, clk_osc = 1'b0;
  logic por = 1'b1, ext_rst_n = 1'b1, wake = 1'b0;
  logic pwrt_en_n = 1'b0, osc_xtal = 1'b1;
  logic core_rst;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk_osc = ~clk_osc;
  always #10  clk_rc  = ~clk_rc;

  pwrup_rst_seq #(.PWRT_TICKS(P), .OST_CYCLES(OST)) u_dut (
    .clk_rc(clk_rc), .clk_osc(clk_osc), .por(por), .ext_rst_n(ext_rst_n),
    .wake(wake), .pwrt_en_n(pwrt_en_n), .osc_xtal(osc_xtal), .core_rst(core_rst)
  );

  always @(posedge clk_osc) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_osc); #1;
  endtask

  // Power-on pulse with the given configuration; returns edges to release
  task automatic power_up(input bit xtal, input bit en_n, input bit pin, output int n);
    @(negedge clk_osc);
    osc_xtal = xtal; pwrt_en_n = en_n; ext_rst_n = pin; por = 1'b1;
    repeat (3) step();
    chk(core_rst === 1'b1, "R1 por holds reset", int'(core_rst), 1);
    @(negedge clk_osc); por = 1'b0;
    n = 0;
    do begin step(); n++; end while (core_rst !== 1'b0 && n < 3000);
  endtask

  task automatic t_xtal_pwrt();
    int n;
    power_up(1'b1, 1'b0, 1'b1, n);
    // R2 + R4: (P-1)*RAT .. P*RAT RC window, +2..4 sync, +1 wait, +OST run
    chk(n >= (P-1)*RAT + 2 + 1 + OST && n <= P*RAT + 4 + 1 + OST + 1,
        "R2/R4 xtal total", n, P*RAT + OST + 3);
  endtask

  task automatic t_rc_pwrt();
    int n;
    power_up(1'b0, 1'b0, 1'b1, n);
    chk(n >= (P-1)*RAT + 3 && n <= P*RAT + 5, "R5 rc total", n, P*RAT + 3);
  endtask

  task automatic t_xtal_nopwrt();
    int n;
    power_up(1'b1, 1'b1, 1'b1, n);
    chk(n >= OST + 2 && n <= OST + 4, "R3 skip pwrt", n, OST + 3);
  endtask

  task automatic t_rc_nopwrt();
    int n;
    power_up(1'b0, 1'b1, 1'b1, n);
    chk(n >= 2 && n <= 4, "R6 no timeout", n, 3);
  endtask

  task automatic t_wake_xtal();
    int highs = 0;
    @(negedge clk_osc); wake = 1'b1;
    step();
    @(negedge clk_osc); wake = 1'b0;
    chk(core_rst === 1'b1, "R7 wake raises", int'(core_rst), 1);
    for (int i = 1; i < OST; i++) begin
      step();
      if (core_rst === 1'b1) highs++;
    end
    chk(highs == OST - 1, "R7 wake hold", highs + 1, OST);
    step();
    chk(core_rst === 1'b0, "R7 wake release", int'(core_rst), 0);
  endtask

  task automatic t_wake_rc();
    int highs = 0;
    @(negedge clk_osc); wake = 1'b1;
    step();
    @(negedge clk_osc); wake = 1'b0;
    for (int i = 0; i < OST + 20; i++) begin
      if (core_rst !== 1'b0) highs++;
      step();
    end
    chk(highs == 0, "R8 rc wake ignored", highs, 0);
  endtask

  task automatic t_pin_held();
    int n;
    power_up(1'b1, 1'b0, 1'b0, n);
    chk(core_rst === 1'b1, "R9 pin holds past expiry", int'(core_rst), 1);
    @(negedge clk_osc); ext_rst_n = 1'b1;
    n = 0;
    do begin step(); n++; end while (core_rst !== 1'b0 && n < 50);
    chk(n == 2, "R9 release after pin", n, 2);
  endtask

  task automatic t_pin_runtime();
    int n;
    @(negedge clk_osc); ext_rst_n = 1'b0;
    step(); step();
    chk(core_rst === 1'b1, "R9 pin asserts reset", int'(core_rst), 1);
    repeat (10) step();
    @(negedge clk_osc); ext_rst_n = 1'b1;
    n = 0;
    do begin step(); n++; end while (core_rst !== 1'b0 && n < 50);
    chk(n == 2, "R9 no timer rerun", n, 2);
  endtask

  initial begin
    repeat (4) step();
    chk(core_rst === 1'b1, "R1 reset at start", int'(core_rst), 1);
    t_xtal_pwrt();
    t_wake_xtal();
    t_pin_runtime();
    t_rc_pwrt();
    t_wake_rc();
    t_xtal_nopwrt();
    t_wake_xtal();
    t_rc_nopwrt();
    t_pin_held();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule